// File: doc/BRIEF.md
# Store Ordering Buffer with Fence

This block sits between a core and the memory system and holds stores until memory accepts them. Each store arrives with an ordering class. A strict store becomes visible only after every older store in the buffer has completed. A relaxed store can issue as soon as the memory port can take it. It may therefore overtake older stores that are still waiting, and a later store may also overtake it. Relaxed stores see lower latency in exchange for a weaker order.

The memory write port uses a valid/ready handshake. Each issued store carries a tag, which is the index of its buffer slot. The memory returns completions with that tag in any order and after any delay. A slot stays occupied from acceptance until its completion returns.

A fence request is a level that the requester holds until it sees the acknowledge. While the request is high, the buffer accepts no new stores. The acknowledge is a one-cycle pulse. It is raised once no relaxed store remains in the buffer. Strict stores still in flight do not delay it.

Top module: `store_order_buf`

## Requirements
- R1: After reset, `st_full`, `mem_valid` and `fence_ack` are all low.
- R2: A store is accepted on a clock edge where `st_valid` is high, `st_full` is low and `fence_req` is low. The buffer holds 8 stores, and `st_full` is high exactly when all 8 slots are occupied.
- R3: A store offered while `st_full` is high is dropped and never appears on the memory port.
- R4: A strict store (`st_relaxed`=0) is presented on the memory port only after every older store, of either class, has completed.
- R5: A relaxed store (`st_relaxed`=1) is presented on the memory port while older stores are still waiting or outstanding.
- R6: Among the stores that are allowed to issue, the oldest is presented first.
- R7: `mem_tag` is the slot index (0 to 7). The eight occupied slots carry distinct tags. A completion (`cpl_valid` with `cpl_tag`) frees that slot, and completions may arrive in any order.
- R8: `fence_ack` pulses high for exactly one cycle while `fence_req` is held. The pulse comes no earlier than the cycle after the last relaxed store completes, and no later than 3 cycles after that completion.
- R9: A fence is acknowledged while strict stores are still outstanding.
- R10: A store offered while `fence_req` is high is dropped and never appears on the memory port.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_tag`, `mem_addr` and `mem_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_relaxed | input | 1 | 1 = relaxed store, 0 = strict store |
| st_full | output | 1 | All slots occupied |
| fence_req | input | 1 | Fence request, held until acknowledged |
| fence_ack | output | 1 | One-cycle fence acknowledge |
| mem_valid | output | 1 | Store presented to memory |
| mem_ready | input | 1 | Memory accepts the presented store |
| mem_addr | output | AW | Address of presented store |
| mem_data | output | DW | Data of presented store |
| mem_tag | output | TW | Slot index of presented store |
| cpl_valid | input | 1 | Completion returned |
| cpl_tag | input | TW | Slot index being completed |

## Verification
The hardest state to reach is a pending fence with several things true at once. At least one strict store and two relaxed stores are in flight, and a new store is offered in the same window. The bench keeps `mem_ready` high so that all three stores issue. It then withholds every completion and raises the fence. Next it returns the relaxed completions in reverse order and leaves the strict store outstanding. This shows that the acknowledge waits only for the relaxed set and that the store offered during the fence never reaches memory.

// File: rtl/store_order_buf.sv
module store_order_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          st_relaxed,
  output logic          st_full,
  input  logic          fence_req,
  output logic          fence_ack,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [TW-1:0] mem_tag,
  input  logic          cpl_valid,
  input  logic [TW-1:0] cpl_tag
);

  logic [DEPTH-1:0] vld, iss, rlx, elig, pick, cpl_vec;
  logic [DEPTH-1:0] older [DEPTH];
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [TW-1:0]    free_tag, pick_tag, hold_tag;
  logic             hold_vld, accept, issue, ack_q, ack_done;

  assign cpl_vec = cpl_valid ? (DEPTH'(1) << cpl_tag) : '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign elig[i] = vld[i] & ~iss[i] & (rlx[i] | ~|older[i]);
    assign pick[i] = elig[i] & ~|(older[i] & elig);
  end

  always_comb begin
    free_tag = '0;
    pick_tag = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i])  free_tag = TW'(i);
      if (pick[i])  pick_tag = TW'(i);
    end
  end

  assign st_full   = &vld;
  assign accept    = st_valid & ~st_full & ~fence_req;
  assign mem_valid = hold_vld | (|pick);
  assign mem_tag   = hold_vld ? hold_tag : pick_tag;
  assign mem_addr  = addr_q[mem_tag];
  assign mem_data  = data_q[mem_tag];
  assign issue     = mem_valid & mem_ready;
  assign fence_ack = ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      iss      <= '0;
      rlx      <= '0;
      hold_vld <= 1'b0;
      hold_tag <= '0;
      ack_q    <= 1'b0;
      ack_done <= 1'b0;
      for (int i = 0; i < DEPTH; i++) older[i] <= '0;
    end else begin
      hold_vld <= mem_valid & ~mem_ready;
      hold_tag <= mem_tag;
      if (issue) iss[mem_tag] <= 1'b1;
      for (int i = 0; i < DEPTH; i++) older[i] <= older[i] & ~cpl_vec;
      if (cpl_valid) begin
        vld[cpl_tag] <= 1'b0;
        iss[cpl_tag] <= 1'b0;
      end
      if (accept) begin
        vld[free_tag]   <= 1'b1;
        iss[free_tag]   <= 1'b0;
        rlx[free_tag]   <= st_relaxed;
        older[free_tag] <= vld & ~cpl_vec;
      end
      ack_q    <= fence_req & ~ack_done & ~ack_q & ~|(vld & rlx);
      ack_done <= fence_req & (ack_done | ack_q);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q[free_tag] <= st_addr;
      data_q[free_tag] <= st_data;
    end
  end

endmodule

module store_order_buf_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_full,
  input logic             fence_req,
  input logic             fence_ack,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [TW-1:0]    mem_tag,
  input logic [AW-1:0]    mem_addr,
  input logic [DEPTH-1:0] vld,
  input logic [DEPTH-1:0] iss,
  input logic [DEPTH-1:0] rlx
);

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fence_ack |=> !fence_ack);  // R8

  AST_ACK_NO_RELAXED: assert property (@(posedge clk) disable iff (!rst_n)
    fence_ack |-> ((vld & rlx) == '0));  // R8

  AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |=> $countones(vld) <= $past($countones(vld)));  // R3

  AST_FENCE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req |=> $countones(vld) <= $past($countones(vld)));  // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_tag) && $stable(mem_addr)));  // R11

  AST_ISSUE_LIVE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (vld[mem_tag] && !iss[mem_tag]));  // R7

endmodule

bind store_order_buf store_order_buf_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (.*);

// File: tb/sim_store_order_buf.sv
`timescale 1ns/1ps
module sim_store_order_buf;
  localparam int AW = 32, DW = 64, TW = 3;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, st_relaxed = 0, fence_req = 0, mem_ready = 0, cpl_valid = 0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [TW-1:0] cpl_tag = '0;
  logic st_full, fence_ack, mem_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [TW-1:0] mem_tag;

  always #4 clk = ~clk;

  store_order_buf u0 (.*);

  int checks = 0, fails = 0, iss_cnt = 0, ack_cnt = 0;
  logic [AW-1:0] log_addr [256];
  logic [TW-1:0] log_tag  [256];

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      log_addr[iss_cnt] <= mem_addr;
      log_tag[iss_cnt]  <= mem_tag;
      iss_cnt <= iss_cnt + 1;
    end
    if (rst_n && fence_ack) ack_cnt <= ack_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [AW-1:0] a, input bit rel);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = {32'hD0D0, a}; st_relaxed = rel;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic complete(input logic [TW-1:0] t);
    @(negedge clk);
    cpl_valid = 1; cpl_tag = t;
    @(negedge clk);
    cpl_valid = 0;
  endtask

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < iss_cnt; i++) if (log_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic finish_addr(input logic [AW-1:0] a, input string req);
    int k;
    k = find(a);
    chk(k >= 0, req, k, 0);
    if (k >= 0) complete(log_tag[k]);
  endtask

  task automatic t_reset;
    idle(2);
    chk(st_full == 0, "R1", st_full, 0);
    chk(mem_valid == 0, "R1", mem_valid, 0);
    chk(fence_ack == 0, "R1", fence_ack, 0);
    rst_n = 1;
    idle(1);
  endtask

  task automatic t_strict_chain;
    int b;
    b = iss_cnt;
    mem_ready = 1;
    push('h10, 0); push('h20, 0); push('h30, 0);
    idle(4);
    chk(iss_cnt - b == 1, "R4", iss_cnt - b, 1);
    chk(log_addr[b] == 'h10, "R4", log_addr[b], 'h10);
    finish_addr('h10, "R7"); idle(3);
    chk(iss_cnt - b == 2, "R4", iss_cnt - b, 2);
    chk(log_addr[b+1] == 'h20, "R4", log_addr[b+1], 'h20);
    finish_addr('h20, "R7"); idle(3);
    chk(log_addr[b+2] == 'h30, "R4", log_addr[b+2], 'h30);
    finish_addr('h30, "R7"); idle(2);
  endtask

  task automatic t_relaxed_bypass;
    int b;
    b = iss_cnt;
    push('h40, 0); push('h50, 0); push('h60, 1);
    idle(4);
    chk(iss_cnt - b == 2, "R5", iss_cnt - b, 2);
    chk(log_addr[b+1] == 'h60, "R5", log_addr[b+1], 'h60);
    finish_addr('h60, "R7"); idle(3);
    chk(iss_cnt - b == 2, "R4", iss_cnt - b, 2);
    finish_addr('h40, "R7"); idle(3);
    chk(log_addr[b+2] == 'h50, "R4", log_addr[b+2], 'h50);
    finish_addr('h50, "R7"); idle(2);
  endtask

  task automatic t_oldest_and_hold;
    int b;
    b = iss_cnt;
    mem_ready = 0;
    push('h70, 1); push('h80, 1); push('h90, 0);
    idle(2);
    chk(mem_valid && mem_addr == 'h70, "R11", mem_addr, 'h70);
    idle(3);
    chk(mem_valid && mem_addr == 'h70 && mem_data == {32'hD0D0, 32'h70}, "R11", mem_addr, 'h70);
    mem_ready = 1;
    idle(4);
    chk(iss_cnt - b == 2, "R6", iss_cnt - b, 2);
    chk(log_addr[b] == 'h70 && log_addr[b+1] == 'h80, "R6", log_addr[b], 'h70);
    finish_addr('h80, "R7"); finish_addr('h70, "R7"); idle(3);
    chk(log_addr[b+2] == 'h90, "R4", log_addr[b+2], 'h90);
    finish_addr('h90, "R7"); idle(2);
  endtask

  task automatic t_full;
    int b;
    logic [7:0] seen;
    b = iss_cnt;
    mem_ready = 0;
    for (int i = 0; i < 8; i++) push(AW'('h100 + i), 1);
    idle(1);
    chk(st_full == 1, "R2", st_full, 1);
    push('h1FF, 1);
    mem_ready = 1;
    idle(12);
    chk(iss_cnt - b == 8, "R2", iss_cnt - b, 8);
    seen = '0;
    for (int i = 0; i < 8; i++) seen[log_tag[b+i]] = 1'b1;
    chk(seen == 8'hFF, "R7", seen, 'hFF);
    for (int i = 7; i >= 0; i--) complete(log_tag[b+i]);
    idle(2);
    chk(st_full == 0, "R7", st_full, 0);
    idle(4);
    chk(find('h1FF) < 0, "R3", find('h1FF), -1);
  endtask

  task automatic t_fence_busy;
    int a;
    mem_ready = 1;
    push('h220, 0); push('h200, 1); push('h210, 1);
    idle(3);
    @(negedge clk);
    fence_req = 1;
    a = ack_cnt;
    push('h230, 1);
    idle(4);
    chk(ack_cnt == a, "R8", ack_cnt - a, 0);
    finish_addr('h210, "R7");
    idle(2);
    chk(ack_cnt == a, "R8", ack_cnt - a, 0);
    finish_addr('h200, "R7");
    idle(3);
    chk(ack_cnt == a + 1, "R9", ack_cnt - a, 1);
    idle(4);
    chk(ack_cnt == a + 1, "R8", ack_cnt - a, 1);
    fence_req = 0;
    idle(3);
    chk(find('h230) < 0, "R10", find('h230), -1);
    finish_addr('h220, "R7"); idle(2);
  endtask

  task automatic t_fence_empty;
    int a;
    a = ack_cnt;
    @(negedge clk); fence_req = 1;
    idle(3);
    chk(ack_cnt == a + 1, "R8", ack_cnt - a, 1);
    idle(5);
    chk(ack_cnt == a + 1, "R8", ack_cnt - a, 1);
    fence_req = 0;
    idle(2);
    fence_req = 1;
    idle(3);
    chk(ack_cnt == a + 2, "R8", ack_cnt - a, 2);
    fence_req = 0;
    idle(2);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_strict_chain;
    t_relaxed_bypass;
    t_oldest_and_hold;
    t_full;
    t_fence_busy;
    t_fence_empty;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule